// File: doc/BRIEF.md
# Sample rounder and magnitude mapper

This block reduces a 12-bit two's complement sample to a short code that is used as part of a table address. The sample is either rounded, with ties going to the even neighbour, or truncated. In raw mode the result is the top 6 bits. In quadrant-map mode the result is 7 bits, which the block then splits into a 6-bit unsigned magnitude and a separate sign bit. A control input selects how negative values are turned into magnitudes: arithmetic negation, or bitwise inversion.

One instance serves each of the in-phase and quadrature paths. All controls are sampled together with the sample. The result appears on the outputs one clock later, from a single register stage.

Top module: `smp_rmap`

## Requirements
- R1: While `rst_n` is low, `code_o` and `sign_o` are 0. This holds at once, without waiting for a clock edge.
- R2: Each result appears on the outputs at the first rising clock edge after the inputs that produce it. Until that edge the outputs keep the previous result.
- R3: With `qmap_en_i` = 0 (raw mode), the sample is reduced by dropping its 6 low bits. `code_o` is the resulting 6-bit two's complement value and `sign_o` is its bit 5.
- R4: With `qmap_en_i` = 1, the sample is reduced by dropping its 5 low bits, giving a 7-bit signed value. `sign_o` is that value's bit 6 and `code_o` is its 6-bit magnitude.
- R5: With `round_en_i` = 0, the dropped bits are discarded, so the value rounds toward minus infinity.
- R6: With `round_en_i` = 1, the value rounds to the nearest code. An exact half step goes to the even code (bit 0 = 0).
- R7: If rounding up would exceed the largest positive code, the result saturates there: 31 in raw mode, or magnitude 63 with `sign_o` = 0 in quadrant-map mode.
- R8: With `ones_neg_i` = 0, a negative 7-bit value gives magnitude equal to its negation. The value -64 gives 63.
- R9: With `ones_neg_i` = 1, a negative 7-bit value gives magnitude equal to the bitwise inverse of its low 6 bits, which is -value - 1.
- R10: `ones_neg_i` has no effect on non-negative values in quadrant-map mode, or on any value in raw mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Two's complement input sample |
| round_en_i | input | 1 | 1 = round half to even, 0 = truncate |
| qmap_en_i | input | 1 | 1 = quadrant-map mode (magnitude and sign), 0 = raw mode |
| ones_neg_i | input | 1 | 1 = negate by bitwise inversion, 0 = arithmetic negation |
| code_o | output | 6 | Raw signed code or unsigned magnitude |
| sign_o | output | 1 | Sign of the reduced value |

## Verification
The hardest cases to reach are at the edges of the input range. One is the round-up carry that meets the most positive code. Another is the single input range whose 7-bit value is -64, where arithmetic negation has no 6-bit result. A third is an exact tie on a negative value, where rounding toward even lands on zero. The bench reaches each of these with directed table vectors chosen on those exact codes. It then sweeps all 4096 samples under all eight control combinations, comparing against its own integer model written with shifts and remainders.

// File: rtl/smp_rmap_pkg.sv
package smp_rmap_pkg;
  // Default geometry shared by the block and its checker.
  localparam int unsigned SMP_IN_W   = 12;
  localparam int unsigned SMP_CODE_W = 6;

  // Negation styles chosen by ones_neg_i.
  typedef enum logic {
    NEG_ARITH = 1'b0,
    NEG_INVERT = 1'b1
  } neg_style_e;
endpackage

// File: rtl/smp_round.sv
// Reduces an IN_W-bit signed sample to OUT_W bits by truncation or
// round-half-to-even, saturating at the most positive code.
module smp_round #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 7
) (
  input  logic [IN_W-1:0]  smp_i,
  input  logic             rnd_en_i,
  output logic [OUT_W-1:0] res_o,
  output logic             sat_o
);
  localparam int unsigned DROP = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  // Decides whether the kept part must step up by one.
  function automatic logic step_up(input logic [DROP-1:0] rem,
                                   input logic            lsb);
    logic guard;
    logic sticky;
    guard  = rem[DROP-1];
    sticky = |rem[DROP-2:0];
    return guard & (sticky | lsb);
  endfunction

  logic [OUT_W-1:0] kept;
  logic [DROP-1:0]  rem;
  logic             up;
  logic             at_max;

  assign kept   = smp_i[IN_W-1:DROP];
  assign rem    = smp_i[DROP-1:0];
  assign up     = rnd_en_i & step_up(rem, kept[0]);
  assign at_max = (kept == POS_MAX);
  assign sat_o  = up & at_max;

  always_comb begin
    if (up && !at_max) res_o = kept + OUT_W'(1);
    else               res_o = kept;
  end
endmodule

// File: rtl/smp_mag.sv
// Splits a W-bit signed value into sign and (W-1)-bit magnitude.
module smp_mag
  import smp_rmap_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0]  val_i,
  input  neg_style_e    style_i,
  output logic [W-2:0]  mag_o,
  output logic          sign_o,
  output logic          sat_o
);
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  // Magnitude of a negative value under the chosen negation style.
  function automatic logic [W-2:0] neg_mag(input logic [W-1:0] v,
                                           input neg_style_e   s);
    logic [W-1:0] n;
    if (s == NEG_INVERT) return ~v[W-2:0];
    if (v == NEG_MIN)    return {(W-1){1'b1}};
    n = -v;
    return n[W-2:0];
  endfunction

  assign sign_o = val_i[W-1];
  assign sat_o  = sign_o && (style_i == NEG_ARITH) && (val_i == NEG_MIN);
  assign mag_o  = sign_o ? neg_mag(val_i, style_i) : val_i[W-2:0];
endmodule

// File: rtl/smp_rmap.sv
module smp_rmap
  import smp_rmap_pkg::*;
#(
  parameter int unsigned IN_W   = SMP_IN_W,
  parameter int unsigned CODE_W = SMP_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   sample_i,
  input  logic              round_en_i,
  input  logic              qmap_en_i,
  input  logic              ones_neg_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sign_o
);
  localparam int unsigned MAP_W  = CODE_W + 1;
  localparam int unsigned N_PATH = 2;  // 0 = raw, 1 = quadrant map

  // Per-path results, sign-extended to the wider map width.
  logic [MAP_W-1:0] path_res [N_PATH];
  logic             path_sat [N_PATH];

  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    localparam int unsigned PW = (p == 0) ? CODE_W : MAP_W;
    logic [PW-1:0] res;
    logic          sat;
    smp_round #(.IN_W(IN_W), .OUT_W(PW)) rnd_i (
      .smp_i   (sample_i),
      .rnd_en_i(round_en_i),
      .res_o   (res),
      .sat_o   (sat)
    );
    assign path_res[p] = MAP_W'($signed(res));
    assign path_sat[p] = sat;
  end

  logic [CODE_W-1:0] map_mag;
  logic              map_sign;
  logic              map_sat;

  smp_mag #(.W(MAP_W)) mag_i (
    .val_i  (path_res[1]),
    .style_i(neg_style_e'(ones_neg_i)),
    .mag_o  (map_mag),
    .sign_o (map_sign),
    .sat_o  (map_sat)
  );

  // Named events for the checker.
  logic rnd_sat_w;
  logic mag_sat_w;
  assign rnd_sat_w = qmap_en_i ? path_sat[1] : path_sat[0];
  assign mag_sat_w = qmap_en_i & map_sat;

  logic [CODE_W-1:0] code_d;
  logic              sign_d;
  always_comb begin
    if (qmap_en_i) begin
      code_d = map_mag;
      sign_d = map_sign;
    end else begin
      code_d = path_res[0][CODE_W-1:0];
      sign_d = path_res[0][CODE_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      sign_o <= 1'b0;
    end else begin
      code_o <= code_d;
      sign_o <= sign_d;
    end
  end
endmodule

// File: rtl/smp_rmap_chk.sv
module smp_rmap_chk #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IN_W-1:0]   sample_i,
  input logic              round_en_i,
  input logic              qmap_en_i,
  input logic              ones_neg_i,
  input logic [CODE_W-1:0] code_o,
  input logic              sign_o,
  input logic              rnd_sat_w,
  input logic              mag_sat_w
);
  localparam logic [CODE_W-1:0] ALL1 = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] RAW_MAX = {1'b0, {(CODE_W-1){1'b1}}};

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (code_o == '0 && !sign_o)); // R1

  AST_TRUNC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (qmap_en_i && !round_en_i && !sample_i[IN_W-1]) |=>
      (code_o == $past(sample_i[IN_W-2 -: CODE_W]) && !sign_o)); // R5

  AST_NO_TRUNC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    !round_en_i |-> !rnd_sat_w); // R5

  AST_ROUND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_sat_w |=> (!sign_o && code_o == ($past(qmap_en_i) ? ALL1 : RAW_MAX))); // R7

  AST_MAG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    mag_sat_w |=> (sign_o && code_o == ALL1)); // R8

  AST_INVERT_NO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ones_neg_i |-> !mag_sat_w); // R9

  AST_MAP_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (qmap_en_i && !sample_i[IN_W-1]) |=> !sign_o); // R4
endmodule

bind smp_rmap smp_rmap_chk #(.IN_W(IN_W), .CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_i  (sample_i),
  .round_en_i(round_en_i),
  .qmap_en_i (qmap_en_i),
  .ones_neg_i(ones_neg_i),
  .code_o    (code_o),
  .sign_o    (sign_o),
  .rnd_sat_w (rnd_sat_w),
  .mag_sat_w (mag_sat_w)
);

// File: tb/smp_rmap_tb_top.sv
module smp_rmap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample_i = '0;
  logic        round_en_i = 1'b0;
  logic        qmap_en_i = 1'b0;
  logic        ones_neg_i = 1'b0;
  logic [5:0]  code_o;
  logic        sign_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smp_rmap dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .round_en_i(round_en_i), .qmap_en_i(qmap_en_i), .ones_neg_i(ones_neg_i),
    .code_o(code_o), .sign_o(sign_o)
  );

  // Fields: sample, round, qmap, invert, expected code, expected sign.
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {12'h7FF, 3'b000, 6'd31, 1'b0},  // R5 R3 truncate positive
    {12'h7FF, 3'b100, 6'd31, 1'b0},  // R7 raw round saturates
    {12'h060, 3'b100, 6'd2,  1'b0},  // R6 tie from odd goes up
    {12'h0A0, 3'b100, 6'd2,  1'b0},  // R6 tie at even stays
    {12'hFE0, 3'b100, 6'd0,  1'b0},  // R6 negative tie to zero
    {12'hFC1, 3'b000, 6'd63, 1'b1},  // R5 R3 floor of negative
    {12'h7F0, 3'b110, 6'd63, 1'b0},  // R7 map round saturates
    {12'h800, 3'b010, 6'd63, 1'b1},  // R8 -64 clamps to 63
    {12'hFC0, 3'b010, 6'd2,  1'b1},  // R8 arithmetic negation
    {12'hFC0, 3'b011, 6'd1,  1'b1},  // R9 inversion
    {12'h0A5, 3'b011, 6'd5,  1'b0},  // R10 positive ignores invert
    {12'hF80, 3'b001, 6'd62, 1'b1},  // R10 raw ignores invert
    {12'h030, 3'b110, 6'd2,  1'b0},  // R4 R6 map tie odd up
    {12'hFD0, 3'b110, 6'd2,  1'b1},  // R6 map negative tie even
    {12'hFB0, 3'b110, 6'd2,  1'b1},  // R6 map negative tie odd
    {12'h031, 3'b110, 6'd2,  1'b0}   // R6 above half rounds up
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [5:0] ec, input logic es);
    n_chk++;
    if (code_o !== ec || sign_o !== es) begin
      n_bad++;
      $display("FAIL %s: code=%0d sign=%0b expected code=%0d sign=%0b",
               req, code_o, sign_o, ec, es);
    end
  endtask

  // Integer model from the requirements.
  function automatic void model(input int v, input bit rnd, input bit qm,
                                input bit inv, output logic [5:0] c,
                                output logic s);
    int sh, d, q, r, mx;
    sh = qm ? 5 : 6;
    d  = 1 << sh;
    q  = v >>> sh;
    r  = v - q * d;
    if (rnd && (2 * r > d || (2 * r == d && (q % 2) != 0))) q = q + 1;
    mx = qm ? 63 : 31;
    if (q > mx) q = mx;
    if (qm) begin
      s = (q < 0);
      if (q >= 0)   c = 6'(q);
      else if (inv) c = 6'(-q - 1);
      else          c = 6'((-q > 63) ? 63 : -q);
    end else begin
      c = 6'(q);
      s = (q < 0);
    end
  endfunction

  task automatic apply(input logic [11:0] s, input bit rnd, input bit qm, input bit inv);
    sample_i = s; round_en_i = rnd; qmap_en_i = qm; ones_neg_i = inv;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] ec;
    logic       es;
    apply(12'h7FF, 1'b0, 1'b0, 1'b0);
    #12;
    check("R1 reset state", 6'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:10], VEC[i][9], VEC[i][8], VEC[i][7]);
      @(posedge clk); @(negedge clk);
      check($sformatf("TABLE vector %0d", i), VEC[i][6:1], VEC[i][0]);
    end

    // R2: output holds until the edge, then takes the new result.
    apply(12'h0A5, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    apply(12'hFC0, 1'b0, 1'b1, 1'b0);
    #1 check("R2 hold before edge", 6'd5, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 update after edge", 6'd2, 1'b1);

    // R1: asynchronous reset mid-run.
    rst_n = 1'b0;
    #1 check("R1 async clear", 6'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 held in reset", 6'd0, 1'b0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8 R9 R10: full sweep against the model.
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4096; s++) begin
        logic signed [11:0] sv;
        sv = 12'(s);
        apply(sv, m[2], m[1], m[0]);
        @(posedge clk); @(negedge clk);
        model(int'(sv), m[2], m[1], m[0], ec, es);
        check($sformatf("R3/R4 sweep mode %0d sample %0d", m, s), ec, es);
      end
    end
    finish_run();
  end
endmodule